// File: doc/BRIEF.md
# PWM Output Override Steering Logic

This block is the last stage between a PWM waveform generator and its complementary high-side and low-side output pins. For each channel it picks a drive level for each pin. A software override, when enabled for that pin, wins first. Next comes a current-limit level, which applies only while the current limit is active and the channel is in normal fault mode. If neither applies, the raw PWM signal passes through. The chosen pair can then be exchanged between the two pins. Both pins come from flip-flops.

The override requests are held in an active register. Depending on a mode setting, that register follows the requests on every clock or only when the PWM time base rolls over. The mode setting itself is frozen while the PWM module runs. It only takes a new value while the module is stopped.

Top module: `pwm_out_steer`

## Requirements
- R1: While `rst` is high and on the first edge after it, both pins of every channel are low and the active overrides are cleared. The latching mode is reset to immediate (0).
- R2: With no override enabled and `cl_active` low, `pin_hi` equals the `pwm_hi` of the previous clock and `pin_lo` equals the previous `pwm_lo`.
- R3: With `fault_indep` = 0 and `cl_active` = 1, each pin without an override takes its current-limit level: high pin = `cl_val_hi`, low pin = `cl_val_lo`.
- R4: With `fault_indep` = 1, `cl_val_hi`, `cl_val_lo` and `cl_active` have no effect on either pin.
- R5: With `swap` = 1, the level chosen for the high side drives `pin_lo` and the level chosen for the low side drives `pin_hi`. With `swap` = 0 each level goes to its own pin.
- R6: An active override enable for one side forces that side to its override value, ahead of current-limit and PWM. Each side has its own enable, so the two sides can be overridden independently.
- R7: In immediate mode (latched `sync_sel` = 0), a change on the override inputs is captured on the next clock edge and reaches the pins on the edge after that.
- R8: In boundary mode (latched `sync_sel` = 1), override changes are captured only on an edge where `period_strobe` is high. At all other times the active override holds.
- R9: `sync_sel` is latched only on edges where `run_en` is low. Changes made while `run_en` is high are held off until the module is stopped.
- R10: Each channel's pins depend only on that channel's inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | PWM module running; freezes the latching mode |
| sync_sel | input | 1 | Requested override latching mode: 1 = time-base boundary, 0 = next clock |
| period_strobe | input | 1 | One-cycle pulse at PWM time-base rollover |
| pwm_hi | input | NCH | Raw high-side PWM per channel |
| pwm_lo | input | NCH | Raw low-side PWM per channel |
| cl_active | input | NCH | Current limit active per channel |
| fault_indep | input | NCH | 1 = independent fault mode (current-limit levels ignored) |
| cl_val_hi | input | NCH | Current-limit level for the high side |
| cl_val_lo | input | NCH | Current-limit level for the low side |
| ovr_en_hi | input | NCH | Override enable, high side |
| ovr_en_lo | input | NCH | Override enable, low side |
| ovr_val_hi | input | NCH | Override level, high side |
| ovr_val_lo | input | NCH | Override level, low side |
| swap | input | NCH | Exchange high and low drive between pins |
| pin_hi | output | NCH | Registered high-pin drive |
| pin_lo | output | NCH | Registered low-pin drive |

## Verification
Override forcing, current-limit forcing and pin swapping can all act in the same cycle. The bench provokes every such overlap by sweeping all 2048 combinations of one channel's eleven control and data bits, while the second channel receives the complementary pattern. Each result is judged against a priority-then-swap formula computed in the bench. A second overlap is an override change that arrives while the latching mode or the rollover strobe is also changing. The bench checks, cycle by cycle, that the pins keep the old override until the strobe edge or until the module is stopped.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef struct packed {
    logic en_hi;
    logic en_lo;
    logic val_hi;
    logic val_lo;
  } ovr_t;
endpackage

// File: rtl/steer_sync_mode.sv
module steer_sync_mode (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic sync_sel,
  output logic sync_eff
);
  always_ff @(posedge clk) begin
    if (rst)          sync_eff <= 1'b0;
    else if (!run_en) sync_eff <= sync_sel;
  end

  // R9: mode frozen while running
  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    run_en |=> $stable(sync_eff));
endmodule

// File: rtl/steer_ovr_latch.sv
module steer_ovr_latch
  import steer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sync_eff,
  input  logic period_strobe,
  input  ovr_t req,
  output ovr_t act
);
  logic take;
  assign take = !sync_eff || period_strobe;

  always_ff @(posedge clk) begin
    if (rst)       act <= '0;
    else if (take) act <= req;
  end

  // R8: boundary mode holds between strobes
  a_r8_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
    (sync_eff && !period_strobe) |=> $stable(act));
  // R7: immediate mode follows on next edge
  a_r7_next_edge_capture: assert property (@(posedge clk) disable iff (rst)
    !sync_eff |=> (act == $past(req)));
endmodule

// File: rtl/steer_pair_out.sv
module steer_pair_out
  import steer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ovr_t act,
  input  logic pwm_hi,
  input  logic pwm_lo,
  input  logic cl_active,
  input  logic fault_indep,
  input  logic cl_val_hi,
  input  logic cl_val_lo,
  input  logic swap,
  output logic pin_hi,
  output logic pin_lo
);
  logic cl_force;
  logic sel_hi, sel_lo;

  always_comb begin
    cl_force = cl_active && !fault_indep;
    if (act.en_hi)     sel_hi = act.val_hi;
    else if (cl_force) sel_hi = cl_val_hi;
    else               sel_hi = pwm_hi;
    if (act.en_lo)     sel_lo = act.val_lo;
    else if (cl_force) sel_lo = cl_val_lo;
    else               sel_lo = pwm_lo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_hi <= 1'b0;
      pin_lo <= 1'b0;
    end else begin
      pin_hi <= swap ? sel_lo : sel_hi;
      pin_lo <= swap ? sel_hi : sel_lo;
    end
  end

  // R6: override wins on its own side
  a_r6_override_wins: assert property (@(posedge clk) disable iff (rst)
    (act.en_hi && !swap) |=> (pin_hi == $past(act.val_hi)));
  // R3: current-limit level in normal mode
  a_r3_cl_level: assert property (@(posedge clk) disable iff (rst)
    (!act.en_lo && cl_active && !fault_indep && !swap) |=> (pin_lo == $past(cl_val_lo)));
  // R4: independent mode ignores current-limit
  a_r4_indep_passes_pwm: assert property (@(posedge clk) disable iff (rst)
    (!act.en_hi && !act.en_lo && fault_indep && !swap)
      |=> (pin_hi == $past(pwm_hi) && pin_lo == $past(pwm_lo)));
  // R5: swap exchanges sides
  a_r5_swap_exchange: assert property (@(posedge clk) disable iff (rst)
    (!act.en_hi && !act.en_lo && !cl_active && swap)
      |=> (pin_hi == $past(pwm_lo) && pin_lo == $past(pwm_hi)));
endmodule

// File: rtl/pwm_out_steer.sv
module pwm_out_steer
  import steer_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_en,
  input  logic           sync_sel,
  input  logic           period_strobe,
  input  logic [NCH-1:0] pwm_hi,
  input  logic [NCH-1:0] pwm_lo,
  input  logic [NCH-1:0] cl_active,
  input  logic [NCH-1:0] fault_indep,
  input  logic [NCH-1:0] cl_val_hi,
  input  logic [NCH-1:0] cl_val_lo,
  input  logic [NCH-1:0] ovr_en_hi,
  input  logic [NCH-1:0] ovr_en_lo,
  input  logic [NCH-1:0] ovr_val_hi,
  input  logic [NCH-1:0] ovr_val_lo,
  input  logic [NCH-1:0] swap,
  output logic [NCH-1:0] pin_hi,
  output logic [NCH-1:0] pin_lo
);
  logic sync_eff;

  steer_sync_mode u_mode (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .sync_sel (sync_sel),
    .sync_eff (sync_eff)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ovr_t req_c, act_c;
    assign req_c = '{en_hi: ovr_en_hi[c], en_lo: ovr_en_lo[c],
                     val_hi: ovr_val_hi[c], val_lo: ovr_val_lo[c]};

    steer_ovr_latch u_latch (
      .clk           (clk),
      .rst           (rst),
      .sync_eff      (sync_eff),
      .period_strobe (period_strobe),
      .req           (req_c),
      .act           (act_c)
    );

    steer_pair_out u_out (
      .clk         (clk),
      .rst         (rst),
      .act         (act_c),
      .pwm_hi      (pwm_hi[c]),
      .pwm_lo      (pwm_lo[c]),
      .cl_active   (cl_active[c]),
      .fault_indep (fault_indep[c]),
      .cl_val_hi   (cl_val_hi[c]),
      .cl_val_lo   (cl_val_lo[c]),
      .swap        (swap[c]),
      .pin_hi      (pin_hi[c]),
      .pin_lo      (pin_lo[c])
    );
  end
endmodule

// File: tb/pwm_out_steer_tb.sv
module pwm_out_steer_tb;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst, run_en, sync_sel, period_strobe;
  logic [NCH-1:0] pwm_hi, pwm_lo, cl_active, fault_indep, cl_val_hi, cl_val_lo;
  logic [NCH-1:0] ovr_en_hi, ovr_en_lo, ovr_val_hi, ovr_val_lo, swap;
  logic [NCH-1:0] pin_hi, pin_lo;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_out_steer #(.NCH(NCH)) u_dut (
    .clk(clk), .rst(rst), .run_en(run_en), .sync_sel(sync_sel),
    .period_strobe(period_strobe), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .cl_active(cl_active), .fault_indep(fault_indep), .cl_val_hi(cl_val_hi),
    .cl_val_lo(cl_val_lo), .ovr_en_hi(ovr_en_hi), .ovr_en_lo(ovr_en_lo),
    .ovr_val_hi(ovr_val_hi), .ovr_val_lo(ovr_val_lo), .swap(swap),
    .pin_hi(pin_hi), .pin_lo(pin_lo)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pins(hi,lo) actual=%b expected=%b", req, act, exp);
    end
  endtask

  // bit map: 0 pwm_hi,1 pwm_lo,2 cl_active,3 fault_indep,4 cl_val_hi,5 cl_val_lo,
  //          6 ovr_en_hi,7 ovr_en_lo,8 ovr_val_hi,9 ovr_val_lo,10 swap
  task automatic apply(input int ch, input logic [10:0] b);
    pwm_hi[ch] = b[0];  pwm_lo[ch] = b[1];  cl_active[ch] = b[2];
    fault_indep[ch] = b[3]; cl_val_hi[ch] = b[4]; cl_val_lo[ch] = b[5];
    ovr_en_hi[ch] = b[6]; ovr_en_lo[ch] = b[7];
    ovr_val_hi[ch] = b[8]; ovr_val_lo[ch] = b[9]; swap[ch] = b[10];
  endtask

  function automatic logic [1:0] model(input logic [10:0] b);
    logic hi, lo;
    logic clf;
    clf = b[2] & ~b[3];
    hi = b[6] ? b[8] : (clf ? b[4] : b[0]);
    lo = b[7] ? b[9] : (clf ? b[5] : b[1]);
    return b[10] ? {lo, hi} : {hi, lo};
  endfunction

  function automatic string tag(input logic [10:0] b);
    if (b[6] | b[7])      return "R6 override";
    if (b[2] & ~b[3])     return "R3 current-limit";
    if (b[2] & b[3])      return "R4 independent";
    if (b[10])            return "R5 swap";
    return "R2 passthrough";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; run_en = 1'b0; sync_sel = 1'b0; period_strobe = 1'b0;
    apply(0, 11'h3C3); apply(1, 11'h3C3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset ch0", {pin_hi[0], pin_lo[0]}, 2'b00);
    chk("R1 reset ch1", {pin_hi[1], pin_lo[1]}, 2'b00);
    apply(0, 11'h003); apply(1, 11'h003);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    // override still cleared from reset: pins follow pwm after one edge
    chk("R1 overrides cleared", {pin_hi[0], pin_lo[0]}, 2'b11);

    // exhaustive sweep, immediate mode
    for (int v = 0; v < 2048; v++) begin
      logic [10:0] b0, b1;
      b0 = v[10:0];
      b1 = ~b0;
      apply(0, b0); apply(1, b1);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(tag(b0), {pin_hi[0], pin_lo[0]}, model(b0));
      chk({"R10 ch1 ", tag(b1)}, {pin_hi[1], pin_lo[1]}, model(b1));
    end

    // R7 timing: override reaches pin on second edge
    apply(0, 11'h000); apply(1, 11'h000);
    repeat (2) @(posedge clk); @(negedge clk);
    apply(0, 11'h140);           // ovr_en_hi=1, ovr_val_hi=1
    @(posedge clk); @(negedge clk);
    chk("R7 not yet after one edge", {pin_hi[0], pin_lo[0]}, 2'b00);
    @(posedge clk); @(negedge clk);
    chk("R7 applied after two edges", {pin_hi[0], pin_lo[0]}, 2'b10);

    // R8: boundary mode
    apply(0, 11'h000);
    sync_sel = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    run_en = 1'b1;
    apply(0, 11'h140);
    repeat (4) @(posedge clk); @(negedge clk);
    chk("R8 held without strobe", {pin_hi[0], pin_lo[0]}, 2'b00);
    period_strobe = 1'b1;
    @(posedge clk); @(negedge clk);
    period_strobe = 1'b0;
    chk("R8 one edge after strobe", {pin_hi[0], pin_lo[0]}, 2'b00);
    @(posedge clk); @(negedge clk);
    chk("R8 applied after strobe", {pin_hi[0], pin_lo[0]}, 2'b10);
    apply(0, 11'h280);           // switch override to low side, value 1
    repeat (4) @(posedge clk); @(negedge clk);
    chk("R8 new request held", {pin_hi[0], pin_lo[0]}, 2'b10);

    // R9: mode change while running is held off
    sync_sel = 1'b0;
    repeat (4) @(posedge clk); @(negedge clk);
    chk("R9 mode frozen while running", {pin_hi[0], pin_lo[0]}, 2'b10);
    run_en = 1'b0;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R9 mode taken when stopped", {pin_hi[0], pin_lo[0]}, 2'b01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule